// File: doc/BRIEF.md
# Parallel Self-Synchronizing Line Encoder

This block is the transmit-side line encoder for a high-definition serial video link. Each enabled clock it accepts a word of 20 serial bits. It scrambles them with the self-synchronizing polynomial x^9 + x^4 + 1. It then folds the scrambled bits through an x + 1 stage, which yields a polarity-free NRZI stream. All 20 bits are handled in one clock at the 74.25 MHz word rate. The history needed by both stages is carried from word to word, so the output is identical to that of a bit-serial encoder fed the same stream.

The data is treated as a plain bit stream. Bit 0 of a word is the first bit on the line, and bit 19 of the previous word comes directly before it. The block ignores character and word boundaries.

A single clock enable gates every register. The stream has no valid/ready handshake: the upstream source presents a new word in each enabled cycle. Holding the enable low stalls the encoder completely, with no loss of history. The output is registered and appears one enabled clock after its input word.

Top module: `sdi_tx_encoder`

## Requirements
- R1: Each scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9], where s is the block's own earlier scrambled output. From a cleared state, an all-zero input gives an all-zero output.
- R2: Each output bit is t[n] = s[n] XOR t[n-1]. The NRZI stage acts on the scrambled bits, after scrambling.
- R3: Bit 0 of a word is the earliest serial bit. For a word whose only set bit is bit 0, entered after all-zero history, output bits 1 and 0 are both 1.
- R4: Scrambler and NRZI history cross word boundaries. The bit before bit 0 is bit 19 of the previous enabled word, so a lone 1 keeps producing nonzero output in later all-zero words.
- R5: The output register holds the encoding of the word presented at the previous enabled clock edge, which is a latency of one enabled clock.
- R6: While the enable is low, the output and all history stay unchanged whatever the input. After the stall, encoding continues as if the stall had not occurred.
- R7: The asynchronous reset clears the output and all history to zero at once. Encoding after reset starts from zero history.
- R8: A matching decoder starts from any state. It applies XOR with the previous line bit, then XOR with the bits 4 and 9 earlier. From bit 10 onward it recovers the encoder's input exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Asynchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| din | input | WORD_W (20) | Input word, bit 0 earliest on the line |
| q | output | WORD_W (20) | Registered encoded NRZI word |

## Verification
The bench builds the block with its default parameters: a 20-bit word and taps at 4 and 9. With these values the far tap of every bit from 0 to 8 reaches into the previous word. Every word therefore exercises the cross-boundary history path, as well as the in-word chain of up to two scrambler dependencies per bit. The encoder is compared against a bit-serial model through random words, stalls and a reset in mid-stream. A serial decoder that starts from arbitrary state checks the round trip from the tenth bit on.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;
  localparam int DEF_WORD_W   = 20;
  localparam int DEF_TAP_NEAR = 4;
  localparam int DEF_TAP_FAR  = 9;
endpackage

// File: rtl/enc_scramble.sv
module enc_scramble #(
  parameter int WORD_W   = 20,
  parameter int TAP_NEAR = 4,
  parameter int TAP_FAR  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] scr
);
  localparam int SPAN = WORD_W + TAP_FAR;

  // hist[TAP_FAR-1] is the most recent scrambled bit
  logic [TAP_FAR-1:0] hist;
  logic [TAP_FAR-1:0] hist_nxt;

  always_comb begin
    logic [SPAN-1:0] chain;
    chain = {{WORD_W{1'b0}}, hist};
    for (int i = 0; i < WORD_W; i++) begin
      chain[TAP_FAR+i] = din[i] ^ chain[TAP_FAR+i-TAP_NEAR] ^ chain[i];
    end
    scr      = chain[SPAN-1:TAP_FAR];
    hist_nxt = chain[SPAN-1:WORD_W];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     hist <= '0;
    else if (ce) hist <= hist_nxt;
  end

  // R6: history frozen while the enable is low
  a_r6_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(hist));

  generate
    if (WORD_W >= TAP_FAR) begin : g_carry_chk
      // R4: bit 0 uses scrambled bits from the previous enabled word
      a_r4_word_carry: assert property (@(posedge clk) disable iff (rst)
        ($past(ce) && !$past(rst)) |->
        ((scr[0] ^ din[0]) == ($past(scr[WORD_W-TAP_NEAR]) ^ $past(scr[WORD_W-TAP_FAR]))));
    end
  endgenerate
endmodule

// File: rtl/enc_nrzi.sv
module enc_nrzi #(
  parameter int WORD_W = 20
) (
  input  logic              prev_bit,
  input  logic [WORD_W-1:0] scr,
  output logic [WORD_W-1:0] line
);
  always_comb begin
    logic acc;
    acc = prev_bit;
    for (int i = 0; i < WORD_W; i++) begin
      acc     = acc ^ scr[i];
      line[i] = acc;
    end
  end
endmodule

// File: rtl/sdi_tx_encoder.sv
module sdi_tx_encoder import sdi_enc_pkg::*; #(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int TAP_NEAR = DEF_TAP_NEAR,
  parameter int TAP_FAR  = DEF_TAP_FAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] scr;
  logic [WORD_W-1:0] line;

  enc_scramble #(.WORD_W(WORD_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_scramble (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .scr(scr)
  );

  // The last line bit of the previous word is q's top bit
  enc_nrzi #(.WORD_W(WORD_W)) u_nrzi (
    .prev_bit(q[WORD_W-1]), .scr(scr), .line(line)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (ce) q <= line;
  end

  // R6: output frozen while the enable is low
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

  // R2: first line bit of a word follows the last line bit of the previous word
  a_r2_line_link: assert property (@(posedge clk) disable iff (rst)
    ce |=> (q[0] == ($past(scr[0]) ^ $past(q[WORD_W-1]))));

  // R5: a new scrambled word reaches q one enabled edge later
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    ce |=> ((q[WORD_W-1] ^ $past(q[WORD_W-1])) == ^$past(scr)));
endmodule

// File: tb/sdi_tx_encoder_bench.sv
module sdi_tx_encoder_bench;
  localparam int W = 20;
  localparam int A = 4;
  localparam int K = 9;
  localparam int NLOG = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b0;
  logic [W-1:0] din = '0;
  wire  [W-1:0] q;

  always #5 clk = ~clk;

  sdi_tx_encoder #(.WORD_W(W), .TAP_NEAR(A), .TAP_FAR(K)) u_sdi_tx_encoder (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .q(q)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  logic [K-1:0] rh;   // rh[0] = most recent scrambled bit
  logic         rt;
  logic [W-1:0] in_log  [NLOG];
  logic [W-1:0] out_log [NLOG];

  task automatic report();
    reported = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    rh = '0;
    rt = 1'b0;
  endtask

  task automatic model_word(input logic [W-1:0] w, output logic [W-1:0] t);
    logic s;
    for (int i = 0; i < W; i++) begin
      s    = w[i] ^ rh[A-1] ^ rh[K-1];
      rh   = {rh[K-2:0], s};
      rt   = rt ^ s;
      t[i] = rt;
    end
  endtask

  task automatic drive_word(input logic [W-1:0] w, output logic [W-1:0] got);
    din = w;
    ce  = 1'b1;
    @(negedge clk);
    got = q;
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R7 output cleared in reset", q, '0);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic t_zero_stream();
    logic [W-1:0] got, exp;
    for (int j = 0; j < 3; j++) begin
      drive_word('0, got);
      model_word('0, exp);
      chk("R1 zero input from cleared state", got, '0);
    end
  endtask

  task automatic t_single_pulse();
    logic [W-1:0] got, exp;
    drive_word(20'h00001, got);
    model_word(20'h00001, exp);
    chk("R3 bit0 earliest, low two bits", {18'b0, got[1:0]}, 20'h00003);
    chk("R1 lone one vs serial model", got, exp);
    for (int j = 0; j < 2; j++) begin
      drive_word('0, got);
      model_word('0, exp);
      chk("R4 history carried into zero word", got, exp);
      n_chk++;
      if (got == '0) begin
        n_bad++;
        $display("FAIL R4: actual %h expected nonzero", got);
      end
    end
  endtask

  task automatic t_random();
    logic [W-1:0] got, exp, w;
    for (int j = 0; j < NLOG; j++) begin
      w = W'($urandom);
      drive_word(w, got);
      model_word(w, exp);
      in_log[j]  = w;
      out_log[j] = got;
      chk("R2 R5 random word vs serial model", got, exp);
    end
  endtask

  task automatic t_stall();
    logic [W-1:0] got, exp, held, w;
    held = q;
    ce = 1'b0;
    for (int j = 0; j < 4; j++) begin
      din = W'($urandom);
      @(negedge clk);
      chk("R6 output held while enable low", q, held);
    end
    for (int j = 0; j < 3; j++) begin
      w = W'($urandom);
      drive_word(w, got);
      model_word(w, exp);
      chk("R6 resume after stall", got, exp);
    end
  endtask

  task automatic t_round_trip();
    logic [K-1:0] dh;
    logic dp, nrz;
    logic [W-1:0] rec, mask;
    dh = '1;
    dp = 1'b1;
    for (int j = 0; j < NLOG; j++) begin
      for (int i = 0; i < W; i++) begin
        nrz    = out_log[j][i] ^ dp;
        dp     = out_log[j][i];
        rec[i] = nrz ^ dh[A-1] ^ dh[K-1];
        dh     = {dh[K-2:0], nrz};
      end
      mask = (j == 0) ? ~W'(20'h003FF) : '1;
      chk("R8 decoder recovers input", rec & mask, in_log[j] & mask);
    end
  endtask

  task automatic t_mid_reset();
    logic [W-1:0] got, exp, w;
    drive_word(20'hA5A5A, got);
    model_word(20'hA5A5A, exp);
    ce  = 1'b0;
    rst = 1'b1;
    #1;
    chk("R7 async clear", q, '0);
    @(negedge clk);
    chk("R7 still clear", q, '0);
    rst = 1'b0;
    model_reset();
    for (int j = 0; j < 3; j++) begin
      w = W'($urandom);
      drive_word(w, got);
      model_word(w, exp);
      chk("R7 restart from zero history", got, exp);
    end
  endtask

  initial begin
    t_reset_state();
    t_zero_stream();
    t_single_pulse();
    t_random();
    t_stall();
    t_round_trip();
    t_mid_reset();
    if (!reported) report();
  end

  initial begin
    #1000000;
    if (!reported) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule